// File: doc/BRIEF.md
# SMBus-style block register target

This block is a two-wire serial target that sits in front of a small bank of byte-wide control registers, for example the per-output enable bits of a clock distribution device. It samples the serial clock and data lines through synchronizers running on a fast system clock. It pulls the data line low through an output-enable pin, so the pad stays open-drain. It answers only to one fixed 7-bit device address. The full register bank is always visible on a parallel output bus.

Four operations are offered. In a block write, the controller sends a command byte, then a byte count, then any number of data bytes. In a block read, the target first reports how many registers lie between the start index and the end of the bank, then streams those registers. In both block forms the registers are walked in ascending order from the index. Byte write and byte read touch exactly one register and carry no count. Bit 7 of the command picks byte mode, and a configuration input can force byte mode for every command. Bits 6..0 of the command are the register index.

Top module: `smb_blk_target`

## Requirements
- R1: The target acknowledges only the address byte whose upper seven bits are 1101011 (D6h to write, D7h to read). Any other address gets no ACK, and the transfer that follows has no effect on the registers.
- R2: Block write (command bit 7 = 0): after the command and an acknowledged count byte, each data byte is ACKed and stored. The first goes to the index in command bits 6..0, and each later byte goes to the next higher index.
- R3: Block read: after a repeated START and the read address, the first byte sent is the count NREG minus the start index. The registers from the start index upward follow, each sent most significant bit first.
- R4: When the controller NACKs a byte sent by the target, the target stops transmitting and releases SDA. It then waits for the next START.
- R5: A STOP after any complete data byte ends a block write. Every byte already ACKed stays stored, and a partial byte in progress is dropped.
- R6: Byte write (command bit 7 = 1): exactly one data byte is stored, at the index. Any further data byte in the same transfer is NACKed and not stored.
- R7: Byte read (command bit 7 = 1): the target returns the indexed register directly, with no count byte in front.
- R8: While `byte_mode_force` is 1, a command with bit 7 = 0 is handled as a byte access.
- R9: Writes to indices at or above NREG are ACKed and discarded. Reads there return 00h, and a block read starting there reports a count of 00h.
- R10: Synchronous reset loads every register with its value from `RESET_VAL` and releases SDA.
- R11: A START or STOP seen in the middle of a byte abandons that byte. A START restarts address reception, and a STOP returns the target to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| byte_mode_force | input | 1 | 1 = treat every command as a single-byte access |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_out | output | NREG*8 | Register bank, register i in bits [8i+7:8i] |

## Verification
Most internal state faults show at the ports within one byte time. A wrong bit counter or a wrong state moves the ACK slot, so `sda_oe` is low where the controller expects an acknowledge, or the read data arrives shifted. A wrong pointer or mode flag shows up on `reg_out` as soon as the next data byte's ACK cycle completes. On the read side it shows as a wrong count or a wrong data byte in the first byte returned. Stale state after an aborted byte is exposed when the next transfer starts: the address ACK goes missing, or a register receives a byte it should not.

// File: rtl/smb_pkg.sv
package smb_pkg;
  // Protocol phase of the target
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN
  } st_t;

  // Meaning of the next byte received in a write transfer
  typedef enum logic [1:0] {
    RL_CMD,
    RL_CNT,
    RL_DATA,
    RL_DONE
  } role_t;
endpackage

// File: rtl/smb_edge.sv
// Synchronizes SCL/SDA and derives bus events in the system clock domain.
module smb_edge #(
  parameter int STAGES = 2  // must be >= 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_regbank.sv
// Control register bank with reset defaults, guarded write and read mux.
module smb_regbank #(
  parameter int                NREG      = 8,
  parameter int                IDXW      = 7,
  parameter logic [NREG*8-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IDXW-1:0]   rd_idx,
  output logic [7:0]        rd_data,
  output logic [7:0]        span,
  output logic [NREG*8-1:0] reg_flat
);
  localparam int              AW     = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [IDXW:0]   NREG_W = (IDXW+1)'(NREG);

  logic [7:0] mem [NREG];
  logic wr_in, rd_in;

  assign wr_in = {1'b0, wr_idx} < NREG_W;
  assign rd_in = {1'b0, rd_idx} < NREG_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= RESET_VAL[i*8 +: 8];
    end else if (wr_en && wr_in) begin
      mem[wr_idx[AW-1:0]] <= wr_data;
    end
  end

  assign rd_data = rd_in ? mem[rd_idx[AW-1:0]] : 8'h00;
  assign span    = rd_in ? 8'(NREG_W - {1'b0, rd_idx}) : 8'h00;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign reg_flat[g*8 +: 8] = mem[g];
  end

  // R9
  oob_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_in) |=> $stable(reg_flat));

  // R6
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(reg_flat));
endmodule

// File: rtl/smb_blk_target.sv
// Serial target with byte and count-prefixed block access to a register bank.
module smb_blk_target
  import smb_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'b1101011,
  parameter int                NREG        = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] RESET_VAL   = 64'h8877_6655_4433_22FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              byte_mode_force,
  output logic              sda_oe,
  output logic [NREG*8-1:0] reg_out
);
  localparam int IDXW = 7;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  st_t  st;
  role_t role;
  logic [3:0]      bitcnt;
  logic [7:0]      sh, tx;
  logic [IDXW-1:0] ptr;
  logic            rw, bmode, span_sent;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [7:0]      wr_data;
  logic [7:0]      rd_data, span, next_tx;
  logic            take_data;

  smb_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smb_regbank #(.NREG(NREG), .IDXW(IDXW), .RESET_VAL(RESET_VAL)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(ptr), .rd_data(rd_data), .span(span), .reg_flat(reg_out)
  );

  // Next byte to transmit: count first in block mode, then register data
  assign take_data = bmode | span_sent;
  assign next_tx   = take_data ? rd_data : span;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      role      <= RL_CMD;
      bitcnt    <= '0;
      sh        <= '0;
      tx        <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      bmode     <= 1'b0;
      span_sent <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw        <= sh[0];
                  sda_oe    <= 1'b1;
                  st        <= ST_ACK_OUT;
                  span_sent <= 1'b0;
                  if (!sh[0]) role <= RL_CMD;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                st     <= ST_ACK_OUT;
                sda_oe <= 1'b1;
                case (role)
                  RL_CMD: begin
                    ptr   <= sh[6:0];
                    bmode <= byte_mode_force | sh[7];
                    role  <= (byte_mode_force | sh[7]) ? RL_DATA : RL_CNT;
                  end
                  RL_CNT: role <= RL_DATA;
                  RL_DATA: begin
                    wr_en   <= 1'b1;
                    wr_idx  <= ptr;
                    wr_data <= sh;
                    if (ptr != '1) ptr <= ptr + 1'b1;
                    if (bmode) role <= RL_DONE;
                  end
                  default: sda_oe <= 1'b0;  // extra byte after a byte write
                endcase
              end
            end
          end
          ST_ACK_OUT: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              if (rw) begin
                st     <= ST_TX;
                tx     <= next_tx;
                sda_oe <= ~next_tx[7];
                if (take_data) begin
                  if (ptr != '1) ptr <= ptr + 1'b1;
                end else begin
                  span_sent <= 1'b1;
                end
              end else begin
                st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= ST_ACK_IN;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) begin
              if (sda_s) st <= ST_IDLE;
            end else if (scl_fall) begin
              bitcnt <= '0;
              st     <= ST_TX;
              tx     <= next_tx;
              sda_oe <= ~next_tx[7];
              if (take_data) begin
                if (ptr != '1) ptr <= ptr + 1'b1;
              end else begin
                span_sent <= 1'b1;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // R1
  foreign_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADDR && scl_fall && bitcnt == 4'd8 && sh[7:1] != DEV_ADDR &&
     !start_ev && !stop_ev) |=> (!sda_oe && st == ST_IDLE));

  // R4
  master_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK_IN && scl_rise && sda_s && !start_ev && !stop_ev)
    |=> (st == ST_IDLE && !sda_oe));

  // R11
  start_abort_chk: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (st == ST_ADDR && bitcnt == 4'd0 && !sda_oe));

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (st == ST_IDLE && !sda_oe));

  // R6
  byte_single_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RX && role == RL_DONE && scl_fall && bitcnt == 4'd8 &&
     !start_ev && !stop_ev) |=> (!wr_en && !sda_oe));
endmodule

// File: tb/tb_smb_blk_target.sv
module tb_smb_blk_target;
  localparam int NREG = 8;
  localparam int Q    = 8;  // system clocks per quarter bit
  localparam logic [NREG*8-1:0] DEFV = 64'h8877_6655_4433_22FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic force_b = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] reg_out;
  logic sda_w;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [NREG];

  always #2.5 clk = ~clk;

  assign sda_w = m_sda & ~sda_oe;

  smb_blk_target dut (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_w),
    .byte_mode_force(force_b), .sda_oe(sda_oe), .reg_out(reg_out)
  );

  task automatic waitq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [NREG*8-1:0] exp_flat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = exp_r[i];
    return f;
  endfunction

  task automatic chk_regs(input string req);
    chk(reg_out == exp_flat(), req, reg_out, exp_flat());
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitq();
    m_scl = 1'b1; waitq();
    m_sda = 1'b0; waitq();
    m_scl = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq();
    m_scl = 1'b1; waitq();
    m_sda = 1'b1; waitq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; waitq();
      m_scl = 1'b1; waitq(); waitq();
      m_scl = 1'b0; waitq();
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; waitq();
    m_scl = 1'b1; waitq();
    ack = ~sda_w; waitq();
    m_scl = 1'b0; waitq();
  endtask

  task automatic rd_byte(input bit nack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(); m_scl = 1'b1;
      waitq(); d[i] = sda_w;
      waitq(); m_scl = 1'b0;
      waitq();
    end
    m_sda = nack; waitq();
    m_scl = 1'b1; waitq(); waitq();
    m_scl = 1'b0; waitq();
    m_sda = 1'b1;
  endtask

  // Address + command, then repeated START with read address
  task automatic read_setup(input logic [7:0] cmd, output bit acks);
    bit a;
    acks = 1'b1;
    bus_start();
    wr_byte(8'hD6, a); acks &= a;
    wr_byte(cmd, a);   acks &= a;
    bus_start();
    wr_byte(8'hD7, a); acks &= a;
  endtask

  task automatic t_reset();
    chk(reg_out == DEFV, "R10 reset defaults", reg_out, DEFV);
    chk(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
  endtask

  task automatic t_foreign();
    bit a1, a2;
    bus_start();
    wr_byte(8'hA0, a1);
    wr_byte(8'h01, a2);
    bus_stop();
    chk(a1 == 1'b0, "R1 foreign address not acked", a1, 0);
    chk(a2 == 1'b0, "R1 no ack after foreign address", a2, 0);
    bus_start();
    wr_byte(8'hD4, a1);  // 1101010 + W, one bit off
    bus_stop();
    chk(a1 == 1'b0, "R1 near-miss address not acked", a1, 0);
    chk_regs("R1 registers untouched");
  endtask

  task automatic t_block_write();
    bit a, all;
    all = 1'b1;
    bus_start();
    wr_byte(8'hD6, a); all &= a;
    wr_byte(8'h01, a); all &= a;
    wr_byte(8'h03, a); all &= a;
    wr_byte(8'h11, a); all &= a;
    wr_byte(8'h2C, a); all &= a;
    wr_byte(8'hE3, a); all &= a;
    bus_stop();
    exp_r[1] = 8'h11; exp_r[2] = 8'h2C; exp_r[3] = 8'hE3;
    chk(all, "R2 every byte acked", all, 1);
    chk_regs("R2 ascending block write");
  endtask

  task automatic t_block_read();
    bit acks;
    logic [7:0] d;
    read_setup(8'h01, acks);
    chk(acks, "R3 setup acked", acks, 1);
    rd_byte(1'b0, d);
    chk(d == 8'd7, "R3 count byte", d, 7);
    rd_byte(1'b0, d);
    chk(d == 8'h11, "R3 data idx1", d, 8'h11);
    rd_byte(1'b0, d);
    chk(d == 8'h2C, "R3 data idx2", d, 8'h2C);
    rd_byte(1'b1, d);
    chk(d == 8'hE3, "R3 data idx3", d, 8'hE3);
    waitq();
    chk(sda_oe == 1'b0, "R4 released after nack", sda_oe, 0);
    bus_stop();
    read_setup(8'h07, acks);
    rd_byte(1'b0, d);
    chk(d == 8'd1, "R3 count at last index", d, 1);
    rd_byte(1'b1, d);
    chk(d == 8'h88, "R3 last register", d, 8'h88);
    bus_stop();
    chk_regs("R4 read leaves registers");
  endtask

  task automatic t_byte_write();
    bit a, all, ax;
    all = 1'b1;
    bus_start();
    wr_byte(8'hD6, a); all &= a;
    wr_byte(8'h86, a); all &= a;
    wr_byte(8'hC3, a); all &= a;
    wr_byte(8'h99, ax);
    bus_stop();
    exp_r[6] = 8'hC3;
    chk(all, "R6 byte write acked", all, 1);
    chk(ax == 1'b0, "R6 extra byte nacked", ax, 0);
    chk_regs("R6 single register written");
  endtask

  task automatic t_byte_read();
    bit acks;
    logic [7:0] d;
    read_setup(8'h86, acks);
    rd_byte(1'b1, d);
    bus_stop();
    chk(acks && d == 8'hC3, "R7 byte read without count", d, 8'hC3);
  endtask

  task automatic t_force();
    bit a, all, acks;
    logic [7:0] d;
    all = 1'b1;
    force_b = 1'b1;
    bus_start();
    wr_byte(8'hD6, a); all &= a;
    wr_byte(8'h02, a); all &= a;
    wr_byte(8'h77, a); all &= a;
    bus_stop();
    exp_r[2] = 8'h77;
    chk_regs("R8 forced byte write");
    read_setup(8'h02, acks);
    rd_byte(1'b1, d);
    bus_stop();
    force_b = 1'b0;
    chk(all && acks && d == 8'h77, "R8 forced byte read, no count", d, 8'h77);
  endtask

  task automatic t_oob();
    bit a, all, acks;
    logic [7:0] d;
    all = 1'b1;
    bus_start();
    wr_byte(8'hD6, a); all &= a;
    wr_byte(8'h06, a); all &= a;
    wr_byte(8'h04, a); all &= a;
    wr_byte(8'hA1, a); all &= a;
    wr_byte(8'hA2, a); all &= a;
    wr_byte(8'hA3, a); all &= a;
    wr_byte(8'hA4, a); all &= a;
    bus_stop();
    exp_r[6] = 8'hA1; exp_r[7] = 8'hA2;
    chk(all, "R9 out-of-bank bytes acked", all, 1);
    chk_regs("R9 out-of-bank writes dropped");
    read_setup(8'h0A, acks);
    rd_byte(1'b0, d);
    chk(d == 8'h00, "R9 count beyond bank", d, 0);
    rd_byte(1'b1, d);
    chk(d == 8'h00, "R9 data beyond bank", d, 0);
    bus_stop();
  endtask

  task automatic t_early_stop();
    bit a, all;
    all = 1'b1;
    bus_start();
    wr_byte(8'hD6, a); all &= a;
    wr_byte(8'h00, a); all &= a;
    wr_byte(8'h05, a); all &= a;
    wr_byte(8'h5E, a); all &= a;
    send_bits(8'hF0, 4);
    bus_stop();
    exp_r[0] = 8'h5E;
    chk(all, "R5 bytes before stop acked", all, 1);
    chk_regs("R5 early stop keeps bytes, drops partial");
    chk(sda_oe == 1'b0, "R11 stop releases sda", sda_oe, 0);
  endtask

  task automatic t_mid_start();
    bit a, all;
    all = 1'b1;
    bus_start();
    wr_byte(8'hD6, a); all &= a;
    wr_byte(8'h84, a); all &= a;
    send_bits(8'h0F, 3);
    bus_start();
    wr_byte(8'hD6, a); all &= a;
    wr_byte(8'h85, a); all &= a;
    wr_byte(8'h5A, a); all &= a;
    bus_stop();
    exp_r[5] = 8'h5A;
    chk(all, "R11 transfer after mid-byte start acked", all, 1);
    chk_regs("R11 aborted byte not stored");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) exp_r[i] = DEFV[i*8 +: 8];
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    waitq();
    t_reset();
    t_foreign();
    t_block_write();
    t_block_read();
    t_byte_write();
    t_byte_read();
    t_force();
    t_oob();
    t_early_stop();
    t_mid_start();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule